// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a single-master, open-drain I2C bus back to idle before the bus master behind it is enabled. A slave can be left holding the data line low mid-byte, for example after a badly timed reset. A slave can also still be stretching the clock. On a start request the block samples both lines and returns at once with a pass verdict if they are already high. Otherwise it works through a fixed procedure of four phases. It first waits out a clock-stretch window. It then clocks SCL a bounded number of times to free the data line. Next it forces a STOP condition. Finally it reports whether the bus ended up idle.

The block never drives a line high. Each line has an output enable: enable 1 pulls the line low and enable 0 releases it to the pull-up. All delays are counted in microseconds. The microsecond unit comes from a free-running prescaler set by the parameter giving clock cycles per microsecond. The SDA and SCL inputs must already be synchronous to the clock.

Top module: `i2c_bus_rescue`

## Requirements
- R1: While reset is applied and afterwards until a start is accepted, `sda_oe_o`, `scl_oe_o`, `busy_o`, `done_o` and `pass_o` are all 0.
- R2: A start request that sees both lines high raises `done_o` with `pass_o`=1 on the next clock and drives neither line.
- R3: When the bus is not idle at start, SCL read low at any cycle of the watch window ends the sequence with `pass_o`=0 and no line is driven.
- R4: When the bus is not idle at start, no line is driven for a watch window of `WATCH_US` microseconds, within one microsecond of tick quantisation.
- R5: After the window, each time SDA reads low the block pulses SCL. It pulls SCL low for `STEP_US` microseconds, then releases it for `STEP_US` microseconds, then samples again.
- R6: At most `MAX_PULSES` SCL pulses are issued. If SDA is still low after the last one, or the bus is otherwise not idle, the result is fail and no STOP is driven (SDA is never pulled low).
- R7: Once the bus is idle, a STOP is forced in four steps spaced `STEP_US` apart. SCL is pulled low, then SDA is pulled low, then SCL is released, then SDA is released. SDA is only ever pulled low while SCL is held low, and it is only released after SCL has been released.
- R8: The verdict after a forced STOP is the idle check taken `STEP_US` after SDA is released. It is pass only when both lines read high.
- R9: Whenever `busy_o` is 0 both line enables are 0.
- R10: A start request while `busy_o` is 1 is ignored. The running sequence keeps its timing and result, and produces exactly one `done_o`.
- R11: `done_o` is a single-cycle pulse. It coincides with `busy_o` falling, and `pass_o` holds the verdict until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to run the recovery sequence, sampled while idle |
| sda_i | input | 1 | Sampled level of the data line (synchronous to clk) |
| scl_i | input | 1 | Sampled level of the clock line (synchronous to clk) |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| scl_oe_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pass_o | output | 1 | Verdict of the last sequence, 1 = bus idle |

## Verification
The bench counts cycles from the edge that samples the start request. An idle-bus pass is due one cycle later, and a fail from a clock held low during the watch window is due two cycles later. The first SCL pull-down is expected between 2·`WATCH_US`−2 and 2·`WATCH_US`+4 cycles at two cycles per microsecond. Because the prescaler is free-running, a microsecond phase can be up to one tick short. Phase widths are therefore checked against a window of about ±2 cycles around `STEP_US`·2, and never against an exact edge. All outputs are sampled on the falling clock edge, one half cycle after the registers update.

// File: rtl/i2c_rescue_pkg.sv
package i2c_rescue_pkg;

  typedef enum logic [3:0] {
    RS_IDLE,
    RS_WATCH,
    RS_PCHK,
    RS_PLO,
    RS_PHI,
    RS_STP_SCL,
    RS_STP_SDA,
    RS_STP_RSCL,
    RS_STP_RSDA
  } rescue_state_t;

endpackage

// File: rtl/rescue_us_tick.sv
module rescue_us_tick #(
  parameter int CYC_PER_US = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (CYC_PER_US > 1) begin : g_div
      localparam int CW = $clog2(CYC_PER_US);
      localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_n;

      always_comb begin
        if (cnt_q == LAST) cnt_n = '0;
        else               cnt_n = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_n;
      end

      assign tick_o = (cnt_q == LAST);
    end else begin : g_nodiv
      assign tick_o = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/rescue_us_timer.sv
module rescue_us_timer #(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_n;
  logic          cnt_en;

  // load wins over a coincident tick
  assign cnt_en = load_i | (tick_i & (cnt_q != '0));

  always_comb begin
    if (load_i) cnt_n = val_i;
    else        cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rescue_fsm.sv
module rescue_fsm
  import i2c_rescue_pkg::*;
#(
  parameter int MAX_PULSES = 10,
  parameter int WATCH_US   = 1024,
  parameter int STEP_US    = 10,
  parameter int TW         = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          sda_i,
  input  logic          scl_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          sda_oe_o,
  output logic          scl_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o
);

  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] PC_MAX   = PW'(MAX_PULSES);
  localparam logic [TW-1:0] T_WATCH  = TW'(WATCH_US);
  localparam logic [TW-1:0] T_STEP   = TW'(STEP_US);

  rescue_state_t st_q, st_n;
  logic [PW-1:0] pc_q, pc_n;
  logic          done_q, done_n;
  logic          pass_q, pass_n;
  logic          sda_oe_q, sda_oe_n;
  logic          scl_oe_q, scl_oe_n;
  logic          bus_idle;

  assign bus_idle = sda_i & scl_i;

  always_comb begin
    st_n       = st_q;
    pc_n       = pc_q;
    done_n     = 1'b0;
    pass_n     = pass_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = T_STEP;
    unique case (st_q)
      RS_IDLE: begin
        if (start_i) begin
          if (bus_idle) begin
            done_n = 1'b1;
            pass_n = 1'b1;
          end else begin
            pass_n     = 1'b0;
            pc_n       = '0;
            st_n       = RS_WATCH;
            tmr_load_o = 1'b1;
            tmr_val_o  = T_WATCH;
          end
        end
      end
      RS_WATCH: begin
        if (!scl_i) begin
          st_n   = RS_IDLE;
          done_n = 1'b1;
          pass_n = 1'b0;
        end else if (tmr_zero_i) begin
          st_n = RS_PCHK;
        end
      end
      RS_PCHK: begin
        if (!sda_i && (pc_q < PC_MAX)) begin
          st_n       = RS_PLO;
          pc_n       = pc_q + 1'b1;
          tmr_load_o = 1'b1;
        end else if (bus_idle) begin
          st_n       = RS_STP_SCL;
          tmr_load_o = 1'b1;
        end else begin
          st_n   = RS_IDLE;
          done_n = 1'b1;
          pass_n = 1'b0;
        end
      end
      RS_PLO: begin
        if (tmr_zero_i) begin
          st_n       = RS_PHI;
          tmr_load_o = 1'b1;
        end
      end
      RS_PHI: begin
        if (tmr_zero_i) st_n = RS_PCHK;
      end
      RS_STP_SCL: begin
        if (tmr_zero_i) begin
          st_n       = RS_STP_SDA;
          tmr_load_o = 1'b1;
        end
      end
      RS_STP_SDA: begin
        if (tmr_zero_i) begin
          st_n       = RS_STP_RSCL;
          tmr_load_o = 1'b1;
        end
      end
      RS_STP_RSCL: begin
        if (tmr_zero_i) begin
          st_n       = RS_STP_RSDA;
          tmr_load_o = 1'b1;
        end
      end
      RS_STP_RSDA: begin
        if (tmr_zero_i) begin
          st_n   = RS_IDLE;
          done_n = 1'b1;
          pass_n = bus_idle;
        end
      end
      default: begin
        st_n = RS_IDLE;
      end
    endcase
  end

  // line enables decoded from the next state, then registered
  always_comb begin
    scl_oe_n = (st_n == RS_PLO) || (st_n == RS_STP_SCL) || (st_n == RS_STP_SDA);
    sda_oe_n = (st_n == RS_STP_SDA) || (st_n == RS_STP_RSCL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RS_IDLE;
      pc_q     <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      pc_q     <= pc_n;
      done_q   <= done_n;
      pass_q   <= pass_n;
      sda_oe_q <= sda_oe_n;
      scl_oe_q <= scl_oe_n;
    end
  end

  assign sda_oe_o = sda_oe_q;
  assign scl_oe_o = scl_oe_q;
  assign busy_o   = (st_q != RS_IDLE);
  assign done_o   = done_q;
  assign pass_o   = pass_q;

endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue #(
  parameter int CYC_PER_US = 4,
  parameter int WATCH_US   = 1024,
  parameter int STEP_US    = 10,
  parameter int MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic sda_oe_o,
  output logic scl_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic pass_o
);

  localparam int T_MAX = (WATCH_US > STEP_US) ? WATCH_US : STEP_US;
  localparam int TW    = $clog2(T_MAX + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          us_tick;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rescue_us_tick #(
    .CYC_PER_US (CYC_PER_US)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (us_tick)
  );

  rescue_us_timer #(
    .TW (TW)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (us_tick),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  rescue_fsm #(
    .MAX_PULSES (MAX_PULSES),
    .WATCH_US   (WATCH_US),
    .STEP_US    (STEP_US),
    .TW         (TW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .sda_i      (sda_i),
    .scl_i      (scl_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .sda_oe_o   (sda_oe_o),
    .scl_oe_o   (scl_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pass_o     (pass_o)
  );

endmodule

// File: rtl/i2c_rescue_chk.sv
module i2c_rescue_chk #(
  parameter int MAX_PULSES = 10
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic sda_i,
  input logic scl_i,
  input logic sda_oe_o,
  input logic scl_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic pass_o
);

  localparam int CW = $clog2(MAX_PULSES + 3);

  logic          scl_oe_prev;
  logic [CW-1:0] scl_pulls;

  // counts SCL pull-downs since the last accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe_prev <= 1'b0;
      scl_pulls   <= '0;
    end else begin
      scl_oe_prev <= scl_oe_o;
      if (start_i && !busy_o)          scl_pulls <= '0;
      else if (scl_oe_o && !scl_oe_prev) scl_pulls <= scl_pulls + 1'b1;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sda_oe_o && !scl_oe_o)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R11

  AST_IDLE_START_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && sda_i && scl_i) |=> (done_o && pass_o)); // R2

  AST_SDA_PULL_UNDER_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> scl_oe_o); // R7

  AST_SDA_FREE_AFTER_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o); // R7

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pulls <= CW'(MAX_PULSES + 1)); // R6

  AST_PASS_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pass_o) |-> $past(sda_i && scl_i)); // R8

endmodule

bind i2c_bus_rescue i2c_rescue_chk #(
  .MAX_PULSES (MAX_PULSES)
) u_rescue_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .start_i  (start_i),
  .sda_i    (sda_i),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .scl_oe_o (scl_oe_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .pass_o   (pass_o)
);

// File: tb/i2c_bus_rescue_tb_top.sv
module i2c_bus_rescue_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int WATCH      = 1024;
  localparam int STEP       = 10;
  localparam int MAXP       = 10;

  logic clk;
  logic rst_n;
  logic start_i;
  logic sda_oe, scl_oe, busy, done, pass;
  logic sda_line, scl_line;

  int   sda_hold;     // slave keeps SDA low for this many SCL releases
  logic scl_hold;     // slave stretches the clock
  logic grab_en;      // slave grabs SDA after the forced STOP
  logic grabbed;
  logic p_scl_oe_s, p_sda_oe_s;

  int   n_checks;
  int   n_fails;

  // measured by run_seq
  int   m_done_cyc, m_scl_rises, m_sda_rises, m_first_drive, m_first_w;
  int   m_order_bad, m_dones, m_busy_at_done, m_done_wide;
  logic m_pass;

  assign sda_line = !sda_oe && (sda_hold == 0) && !grabbed;
  assign scl_line = !scl_oe && !scl_hold;

  i2c_bus_rescue #(
    .CYC_PER_US (CPU),
    .WATCH_US   (WATCH),
    .STEP_US    (STEP),
    .MAX_PULSES (MAXP)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sda_i    (sda_line),
    .scl_i    (scl_line),
    .sda_oe_o (sda_oe),
    .scl_oe_o (scl_oe),
    .busy_o   (busy),
    .done_o   (done),
    .pass_o   (pass)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model
  always @(posedge clk) begin
    p_scl_oe_s <= scl_oe;
    p_sda_oe_s <= sda_oe;
    if (p_scl_oe_s && !scl_oe && sda_hold > 0) sda_hold <= sda_hold - 1;
    if (grab_en && p_sda_oe_s && !sda_oe) grabbed <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // start a sequence and watch the lines until done
  task automatic run_seq(input bit spam, input int limit);
    logic ps, pd;
    int   lo;
    bit   seen;
    m_done_cyc = -1; m_scl_rises = 0; m_sda_rises = 0; m_first_drive = -1;
    m_first_w = -1; m_order_bad = 0; m_dones = 0; m_busy_at_done = 0;
    m_done_wide = 0; m_pass = 1'b0;
    ps = 1'b0; pd = 1'b0; lo = 0; seen = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    for (int cyc = 1; cyc <= limit; cyc++) begin
      @(negedge clk);
      if (seen) begin
        if (done) m_done_wide = 1;
        start_i = 1'b0;
        break;
      end
      start_i = spam && !done;
      if (!spam) start_i = 1'b0;
      if (scl_oe && !ps) begin
        m_scl_rises++;
        if (m_first_drive < 0) m_first_drive = cyc;
      end
      if (scl_oe) lo++;
      if (!scl_oe && ps) begin
        if (m_first_w < 0) m_first_w = lo;
        lo = 0;
      end
      if (sda_oe && !pd) begin
        m_sda_rises++;
        if (!scl_oe) m_order_bad++;
      end
      if (!sda_oe && pd && scl_oe) m_order_bad++;
      if (done) begin
        m_dones++;
        m_done_cyc = cyc;
        m_pass = pass;
        if (busy) m_busy_at_done = 1;
        seen = 1'b1;
      end
      ps = scl_oe; pd = sda_oe;
    end
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; sda_hold = 0; scl_hold = 1'b0;
    grab_en = 1'b0; grabbed = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sda_oe && !scl_oe, "R1", "enables in reset", {sda_oe, scl_oe}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_oe && !scl_oe, "R1", "enables after reset", {sda_oe, scl_oe}, 0);
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!pass, "R1", "pass after reset", pass, 0);
  endtask

  task automatic t_idle_bus();
    run_seq(1'b0, 50);
    chk(m_done_cyc == 1, "R2", "done cycle on idle bus", m_done_cyc, 1);
    chk(m_pass == 1'b1, "R2", "pass on idle bus", m_pass, 1);
    chk(m_scl_rises == 0 && m_sda_rises == 0, "R2", "lines driven",
        m_scl_rises + m_sda_rises, 0);
    chk(m_done_wide == 0 && m_busy_at_done == 0, "R11", "done shape",
        m_done_wide + m_busy_at_done, 0);
    @(negedge clk);
    chk(pass == 1'b1 && !sda_oe && !scl_oe, "R9", "released and held verdict",
        {pass, sda_oe, scl_oe}, 4);
  endtask

  task automatic t_clock_stretch();
    scl_hold = 1'b1;
    run_seq(1'b0, 5000);
    chk(m_done_cyc == 2, "R3", "done cycle with SCL held", m_done_cyc, 2);
    chk(m_pass == 1'b0, "R3", "verdict with SCL held", m_pass, 0);
    chk(m_scl_rises == 0 && m_sda_rises == 0, "R3", "lines driven",
        m_scl_rises + m_sda_rises, 0);
    scl_hold = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stuck_sda(input int holds, input bit spam);
    int expp;
    expp = (holds < MAXP) ? holds : MAXP;
    sda_hold = holds;
    run_seq(spam, 20000);
    chk(m_first_drive >= 2*WATCH - 2 && m_first_drive <= 2*WATCH + 4, "R4",
        "first drive after watch window", m_first_drive, 2*WATCH);
    chk(m_first_w >= 2*STEP - 2 && m_first_w <= 2*STEP + 2, "R5",
        "SCL low pulse width", m_first_w, 2*STEP);
    if (holds <= MAXP) begin
      chk(m_scl_rises == expp + 1, "R5", "SCL pulls incl. STOP", m_scl_rises, expp + 1);
      chk(m_sda_rises == 1, "R7", "SDA pulls in STOP", m_sda_rises, 1);
      chk(m_order_bad == 0, "R7", "STOP ordering faults", m_order_bad, 0);
      chk(m_pass == 1'b1, "R8", "verdict after STOP", m_pass, 1);
    end else begin
      chk(m_scl_rises == MAXP, "R6", "SCL pulls with SDA stuck", m_scl_rises, MAXP);
      chk(m_sda_rises == 0, "R6", "SDA pulled with SDA stuck", m_sda_rises, 0);
      chk(m_pass == 1'b0, "R6", "verdict with SDA stuck", m_pass, 0);
    end
    chk(m_done_wide == 0 && m_busy_at_done == 0, "R11", "done shape",
        m_done_wide + m_busy_at_done, 0);
    if (spam) begin
      chk(m_dones == 1, "R10", "done count with start held", m_dones, 1);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (done || busy) begin
          chk(1'b0, "R10", "extra sequence after done", 1, 0);
          break;
        end
      end
      chk(!busy, "R10", "idle after ignored starts", busy, 0);
    end
    sda_hold = 0;
    @(negedge clk);
  endtask

  task automatic t_grab_after_stop();
    sda_hold = 2; grab_en = 1'b1;
    run_seq(1'b0, 20000);
    chk(m_scl_rises == 3, "R8", "SCL pulls before grab", m_scl_rises, 3);
    chk(m_sda_rises == 1, "R8", "STOP issued", m_sda_rises, 1);
    chk(m_pass == 1'b0, "R8", "verdict with SDA grabbed", m_pass, 0);
    grab_en = 1'b0; grabbed = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    n_checks = 0; n_fails = 0;
    t_reset();
    t_idle_bus();
    t_clock_stretch();
    t_stuck_sda(3, 1'b0);
    t_stuck_sda(MAXP, 1'b0);
    t_stuck_sda(100, 1'b0);
    t_stuck_sda(4, 1'b1);
    t_grab_after_stop();
    finish_run();
  end

endmodule